// File: doc/BRIEF.md
# Keyboard and Border I/O Port

This block is the even-address I/O port of a home-computer video and I/O chip. The CPU reaches it with any I/O cycle whose address bit 0 is low. On a read, the upper address byte chooses which half-rows of an 8×5 key matrix are scanned. Every zero bit in that byte adds one half-row to the scan, and the enabled rows are combined with a bitwise AND. The key bits come back active low, together with a tape input bit and two bits that always read as one.

On a write, the port keeps the whole data byte. Its low fields drive the border colour, the tape output (MIC) and the speaker (EAR).

The same block also decodes a simple joystick port. Any read cycle with address bit 5 low returns the joystick byte. When a tape is not loading, the tape bit echoes the last written output byte. A keyboard-issue pin picks whether it follows EAR alone or EAR and MIC together.

Top module: `kbd_border_port`

## Requirements
- R1: The port claims only I/O cycles whose address bit 0 is 0. A write to an odd address leaves the stored byte unchanged. A read of an odd address with address bit 5 at 1 returns 0xFF.
- R2: On a keyboard read, each address bit 8+i (i = 0..7) that is 0 enables key row i. Row i sits at `key_rows_n[5*i+4:5*i]`. Data bits 4:0 are the bitwise AND of all enabled rows, or 5'b11111 when no row is enabled.
- R3: On a keyboard read, data bits 7 and 5 are always 1.
- R4: While `tape_loading` is 1, the tape bit (data bit 6) of a keyboard read is 0 when `tape_in` is 1, and 1 when `tape_in` is 0.
- R5: While not loading with `issue2_mode` at 1, the tape bit is 0 only when both EAR and MIC of the stored byte are 0.
- R6: While not loading with `issue2_mode` at 0, the tape bit equals the stored EAR bit.
- R7: A write cycle to an even address stores the data byte on the next clock edge. `border` is bits 2:0, `mic_out` is bit 3 and `ear_out` is bit 4, and `out_byte` shows all eight bits.
- R8: Any read cycle with address bit 5 at 0 returns `joy_in`, whatever address bit 0 is. This decode takes priority over the keyboard.
- R9: Reset clears the stored byte, so the border reads 0 and EAR and MIC are both 0.
- R10: Outside a read cycle (`iorq_n` or `rd_n` high), `dout` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | CPU I/O address |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data to the CPU |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| key_rows_n | input | 40 | Eight 5-bit key rows, active low, row i at bits 5i+4..5i |
| tape_in | input | 1 | Tape EAR input, 1 = active |
| tape_loading | input | 1 | 1 while a tape is being loaded |
| joy_in | input | 8 | Joystick state byte |
| issue2_mode | input | 1 | 1 selects the early keyboard-issue tape echo |
| border | output | 3 | Border colour from the stored byte |
| ear_out | output | 1 | Speaker bit from the stored byte |
| mic_out | output | 1 | Tape output bit from the stored byte |
| out_byte | output | 8 | Whole stored output byte |

## Verification
The assertions check these behaviours on every cycle:
- the idle 0xFF bus value;
- joystick priority on any read cycle with address bit 5 low;
- the fixed ones in bits 7 and 5;
- the tape bit while loading;
- the capture of an even-address write on the next edge;
- the stored byte holding steady when no write is claimed;
- the cleared state under reset.

Some behaviours only the bench's scenarios can show:
- the AND across several half-rows for chosen address patterns;
- the two tape-echo rules after specific EAR/MIC writes;
- the rejection of odd-address writes and reads.

These depend on chosen key patterns and on a sequence of writes followed by reads.

// File: rtl/kbp_pkg.sv
package kbp_pkg;

  // Stored output byte, kept whole; low fields drive outputs
  typedef struct packed {
    logic [2:0] spare;
    logic       ear;
    logic       mic;
    logic [2:0] border;
  } out_byte_t;

  // Tape bit seen on a keyboard read when no tape is loading
  function automatic logic echo_bit(input logic issue2, input logic ear,
                                    input logic mic);
    if (issue2) return ear | mic;
    return ear;
  endfunction

  // Tape bit for any mode; loading takes the live input, inverted
  function automatic logic tape_bit(input logic loading, input logic tin,
                                    input logic issue2, input logic ear,
                                    input logic mic);
    if (loading) return ~tin;
    return echo_bit(issue2, ear, mic);
  endfunction

endpackage

// File: rtl/kbp_row_scan.sv
module kbp_row_scan #(
  parameter int ROWS = 8,
  parameter int COLS = 5
) (
  input  logic [ROWS-1:0]      sel_n,
  input  logic [ROWS*COLS-1:0] rows_n,
  output logic [COLS-1:0]      keys_n
);
  logic [COLS-1:0] acc [ROWS+1];

  assign acc[0] = '1;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [COLS-1:0] row_v;
    assign row_v      = rows_n[g*COLS +: COLS];
    assign acc[g + 1] = sel_n[g] ? acc[g] : (acc[g] & row_v);
  end

  assign keys_n = acc[ROWS];
endmodule

// File: rtl/kbp_tape_sel.sv
module kbp_tape_sel
  import kbp_pkg::*;
(
  input  logic loading,
  input  logic tin,
  input  logic issue2,
  input  logic ear,
  input  logic mic,
  output logic tbit
);
  always_comb tbit = tape_bit(loading, tin, issue2, ear, mic);
endmodule

// File: rtl/kbp_out_reg.sv
module kbp_out_reg
  import kbp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wdata,
  output out_byte_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= out_byte_t'(wdata);
  end
endmodule

// File: rtl/kbd_border_port.sv
module kbd_border_port
  import kbp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ROWS    = 8,
  parameter int COLS    = 5,
  parameter int JOY_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           din,
  output logic [7:0]           dout,
  input  logic                 iorq_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [ROWS*COLS-1:0] key_rows_n,
  input  logic                 tape_in,
  input  logic                 tape_loading,
  input  logic [7:0]           joy_in,
  input  logic                 issue2_mode,
  output logic [2:0]           border,
  output logic                 ear_out,
  output logic                 mic_out,
  output logic [7:0]           out_byte
);
  localparam int ROW_LSB = ADDR_W - ROWS;

  // Named events for the checker
  logic rd_cycle, wr_hit, joy_sel, kbd_sel;
  assign rd_cycle = !iorq_n && !rd_n;
  assign wr_hit   = !iorq_n && !wr_n && !addr[0];
  assign joy_sel  = rd_cycle && !addr[JOY_BIT];
  assign kbd_sel  = rd_cycle && addr[JOY_BIT] && !addr[0];

  // Address bits that play no part in selection
  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[ROW_LSB-1:JOY_BIT+1], addr[JOY_BIT-1:1]};

  out_byte_t stored;
  kbp_out_reg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_hit),
    .wdata (din),
    .q     (stored)
  );

  logic [COLS-1:0] keys_n;
  kbp_row_scan #(.ROWS(ROWS), .COLS(COLS)) u_scan (
    .sel_n  (addr[ADDR_W-1:ROW_LSB]),
    .rows_n (key_rows_n),
    .keys_n (keys_n)
  );

  logic tbit;
  kbp_tape_sel u_tape (
    .loading (tape_loading),
    .tin     (tape_in),
    .issue2  (issue2_mode),
    .ear     (stored.ear),
    .mic     (stored.mic),
    .tbit    (tbit)
  );

  logic [7:0] kbd_word;
  always_comb begin
    kbd_word       = 8'hFF;
    kbd_word[4:0]  = keys_n;
    kbd_word[6]    = tbit;
  end

  always_comb begin
    if (joy_sel)      dout = joy_in;
    else if (kbd_sel) dout = kbd_word;
    else              dout = 8'hFF;
  end

  assign border   = stored.border;
  assign ear_out  = stored.ear;
  assign mic_out  = stored.mic;
  assign out_byte = stored;
endmodule

// File: rtl/kbp_checker.sv
module kbp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [7:0]  din,
  input logic [7:0]  dout,
  input logic [7:0]  joy_in,
  input logic        tape_in,
  input logic        tape_loading,
  input logic        rd_cycle,
  input logic        wr_hit,
  input logic [2:0]  border,
  input logic        ear_out,
  input logic        mic_out
);
  // R10
  idle_bus_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cycle |-> dout == 8'hFF);

  // R8
  joy_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cycle && !addr[5]) |-> dout == joy_in);

  // R3
  fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cycle && addr[5] && !addr[0]) |-> (dout[7] && dout[5]));

  // R4
  load_tape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cycle && addr[5] && !addr[0] && tape_loading) |-> dout[6] == !tape_in);

  // R7
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (border == $past(din[2:0]) && mic_out == $past(din[3])
                && ear_out == $past(din[4])));

  // R1
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(border) && $stable(ear_out) && $stable(mic_out)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (border == 3'd0 && !ear_out && !mic_out));
endmodule

bind kbd_border_port kbp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .din          (din),
  .dout         (dout),
  .joy_in       (joy_in),
  .tape_in      (tape_in),
  .tape_loading (tape_loading),
  .rd_cycle     (rd_cycle),
  .wr_hit       (wr_hit),
  .border       (border),
  .ear_out      (ear_out),
  .mic_out      (mic_out)
);

// File: tb/kbd_border_port_bench.sv
`timescale 1ns/1ps
module kbd_border_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  din = 8'h00;
  logic [7:0]  dout;
  logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [39:0] key_rows_n = '1;
  logic        tape_in = 1'b0, tape_loading = 1'b0, issue2_mode = 1'b0;
  logic [7:0]  joy_in = 8'h00;
  logic [2:0]  border;
  logic        ear_out, mic_out;
  logic [7:0]  out_byte;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kbd_border_port u_kbd_border_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .key_rows_n(key_rows_n),
    .tape_in(tape_in), .tape_loading(tape_loading), .joy_in(joy_in),
    .issue2_mode(issue2_mode), .border(border), .ear_out(ear_out),
    .mic_out(mic_out), .out_byte(out_byte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Bench model of the key scan: AND of rows whose high address bit is 0
  function automatic logic [4:0] model_keys(input logic [15:0] a, input logic [39:0] r);
    logic [4:0] k = 5'h1F;
    for (int i = 0; i < 8; i++)
      if (a[8+i] == 1'b0) k = k & r[i*5 +: 5];
    return k;
  endfunction

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; iorq_n = 0; wr_n = 0;
    @(negedge clk);
    iorq_n = 1; wr_n = 1;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; iorq_n = 0; rd_n = 0;
    #2 d = dout;
    @(negedge clk);
    iorq_n = 1; rd_n = 1;
  endtask

  task automatic t_reset;
    check("R9 border", {5'd0, border}, 8'h00);
    check("R9 ear/mic", {6'd0, ear_out, mic_out}, 8'h00);
    #1 check("R10 idle", dout, 8'hFF);
  endtask

  task automatic t_write;
    io_write(16'h00FE, 8'hFD);
    check("R7 border", {5'd0, border}, 8'h05);
    check("R7 mic", {7'd0, mic_out}, 8'h01);
    check("R7 ear", {7'd0, ear_out}, 8'h01);
    check("R7 byte", out_byte, 8'hFD);
  endtask

  task automatic t_odd;
    logic [7:0] d;
    io_write(16'h12FF, 8'h02);
    check("R1 odd write ignored", out_byte, 8'hFD);
    io_read(16'h00FF, d);
    check("R1 odd read", d, 8'hFF);
  endtask

  task automatic t_scan;
    logic [7:0] d;
    logic [15:0] alist [5] = '{16'hFEFE, 16'h7FFE, 16'h00FE, 16'hFFFE, 16'hDBFE};
    for (int i = 0; i < 8; i++) key_rows_n[i*5 +: 5] = ~(5'b1 << (i % 5));
    tape_loading = 1; tape_in = 0;
    foreach (alist[j]) begin
      io_read(alist[j], d);
      check("R2 keys", {3'd0, d[4:0]}, {3'd0, model_keys(alist[j], key_rows_n)});
      check("R3 fixed ones", {6'd0, d[7], d[5]}, 8'h03);
    end
  endtask

  task automatic t_load;
    logic [7:0] d;
    tape_loading = 1; tape_in = 1;
    io_read(16'hFFFE, d);
    check("R4 tape active", {7'd0, d[6]}, 8'h00);
    tape_in = 0;
    io_read(16'hFFFE, d);
    check("R4 tape idle", {7'd0, d[6]}, 8'h01);
  endtask

  task automatic t_echo;
    logic [7:0] d;
    tape_loading = 0; issue2_mode = 1;
    io_write(16'h00FE, 8'h08);           // mic=1 ear=0
    io_read(16'hFFFE, d);
    check("R5 mic only", {7'd0, d[6]}, 8'h01);
    io_write(16'h00FE, 8'h00);           // both 0
    io_read(16'hFFFE, d);
    check("R5 both zero", {7'd0, d[6]}, 8'h00);
    issue2_mode = 0;
    io_write(16'h00FE, 8'h08);
    io_read(16'hFFFE, d);
    check("R6 mic ignored", {7'd0, d[6]}, 8'h00);
    io_write(16'h00FE, 8'h10);           // ear=1
    io_read(16'hFFFE, d);
    check("R6 ear", {7'd0, d[6]}, 8'h01);
  endtask

  task automatic t_joy;
    logic [7:0] d;
    joy_in = 8'h5A;
    io_read(16'h001F, d);
    check("R8 joy odd", d, 8'h5A);
    joy_in = 8'h13;
    io_read(16'h00DE, d);
    check("R8 joy over keyboard", d, 8'h13);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_write;
    t_odd;
    t_scan;
    t_load;
    t_echo;
    t_joy;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule